// File: doc/BRIEF.md
# Programmable-Threshold Dual-Clock FIFO with In-Band Offset Loading

This block is a 9-bit-wide FIFO with separate write and read clocks. It has four flags: empty, full, almost-empty and almost-full. The two almost thresholds are programmable and are held as an empty offset and a full offset. Each offset is split into a low field and a high field, which gives four offset slots in total. Each pointer crosses into the other clock domain as a Gray code through two flops.

There is no separate configuration port. The slots are reached through the FIFO's own data lanes. When the config pin `cfg_n` is low, each enabled write stores `din` into the next slot in a fixed rotation, and each enabled read returns the next slot on `dout`. Software may load only part of the rotation and return to normal traffic; the next config access picks up where the last one stopped. The write side and the read side each keep their own rotation index.

If a config write and a config read are requested on the same edge, the write is done, the read is withheld, and a clash bit reports the conflict.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `cfg_clash`=0 and `dout`=0. Both offsets hold 7 and both rotation indices point at slot 0.
- R2: With `cfg_n`=0 and `wr_en_n`=0, each write-clock edge stores `din` into the selected slot and then advances the index. The slot order is 0 = empty-offset low field, 1 = empty-offset high field, 2 = full-offset low field, 3 = full-offset high field, after which the index returns to 0.
- R3: With `wr_en_n`=1, neither the FIFO memory nor any slot nor the write index changes, in either mode.
- R4: Raising `cfg_n` after loading only one or two slots keeps the write index; the next config write goes to the following slot.
- R5: With `cfg_n`=0 and both read enables low, each read-clock edge puts the slot selected by a separate read index on `dout` and advances that index. The read index follows the same order as R2 and starts at slot 0 after reset.
- R6: For a FIFO of 2^AW entries, the high field holds 0 bits for AW≤8, 1 bit for AW=9, and AW−9 bits above that; the low field holds the remaining bits, taken from `din[LO-1:0]`. The high field takes `din[HI-1:0]`. Unused bits of a slot read back as 0. At the default depth of 512, the low field is 8 bits and the high field is 1 bit.
- R7: With `cfg_n`=1 and `wr_en_n`=0, `din` is written into the FIFO. A read needs both read enables low; `dout` then changes on that read edge to the oldest word. With only one read enable low, nothing is read.
- R8: `full` is 1 when the FIFO holds DEPTH words, and writes while full are dropped.
- R9: A read while `empty` is 1 changes neither `dout` nor the FIFO contents.
- R10: `almost_empty` is 1 exactly when the stored word count is at most the empty offset.
- R11: `almost_full` is 1 exactly when DEPTH minus the word count is at most the full offset.
- R12: When `cfg_n`=0, `wr_en_n`=0 and both read enables are low on the same edge, the slot write goes ahead. The read index and `dout` hold, and `cfg_clash` is 1 after that edge; otherwise `cfg_clash` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write enable |
| cfg_n | input | 1 | Low selects offset-slot access, high selects FIFO access |
| din | input | DATA_W | Write data or slot value |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| dout | output | DATA_W | Registered read data or slot value |
| empty | output | 1 | FIFO holds no words (read domain) |
| full | output | 1 | FIFO holds DEPTH words (write domain) |
| almost_empty | output | 1 | Word count at most the empty offset |
| almost_full | output | 1 | Free space at most the full offset |
| cfg_clash | output | 1 | A config write and a config read met on the last write edge |

## Verification
Slot loading is tried three ways: a partial load of two slots, then normal traffic, then a resumed load that wraps past slot 3. Readback is then expected to show the resumed order and not a restarted one. Data written with high bits set in the high field shows whether the field widths mask correctly. Bursts that stop one word on either side of each threshold separate a `<` comparison from a `<=` comparison in both almost flags. Writing beyond full, reading beyond empty, and reading with only one enable low each show whether a dropped access has leaked into the pointers or into `dout`. A same-edge config write and read shows which side wins.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

  // Offset slot rotation; order is behaviour (R2, R5)
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;

  function automatic int hi_field_bits(input int aw);
    if (aw <= 8) return 0;
    else if (aw == 9) return 1;
    else return aw - 9;
  endfunction

  function automatic ofs_sel_e sel_next(input ofs_sel_e s);
    return ofs_sel_e'(s + 2'd1);
  endfunction

endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/fifo_ofs_bank.sv
module fifo_ofs_bank
  import fifo_ofs_pkg::*;
#(
  parameter int AW      = 9,
  parameter int LO_W    = 8,
  parameter int DATA_W  = 9,
  parameter int DEF_OFS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_n,
  input  logic              wr_en_n,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] din,
  output logic [AW-1:0]     ofs_e,
  output logic [AW-1:0]     ofs_f,
  output logic              clash
);
  localparam logic [31:0] LO_M = (32'd1 << LO_W) - 32'd1;

  ofs_sel_e    sel_q, sel_d;
  logic [AW-1:0] e_q, e_d, f_q, f_d;
  logic        clash_q, clash_d;
  logic        ld_wr;

  function automatic logic [AW-1:0] put_lo(input logic [AW-1:0] cur,
                                           input logic [DATA_W-1:0] d);
    return AW'((32'(cur) & ~LO_M) | (32'(d) & LO_M));
  endfunction

  function automatic logic [AW-1:0] put_hi(input logic [AW-1:0] cur,
                                           input logic [DATA_W-1:0] d);
    return AW'((32'(cur) & LO_M) | ((32'(d) << LO_W) & ~LO_M));
  endfunction

  assign ld_wr = !cfg_n && !wr_en_n;

  always_comb begin
    sel_d   = sel_q;
    e_d     = e_q;
    f_d     = f_q;
    clash_d = ld_wr && rd_req;
    if (ld_wr) begin
      sel_d = sel_next(sel_q);
      unique case (sel_q)
        SEL_E_LO: e_d = put_lo(e_q, din);
        SEL_E_HI: e_d = put_hi(e_q, din);
        SEL_F_LO: f_d = put_lo(f_q, din);
        SEL_F_HI: f_d = put_hi(f_q, din);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SEL_E_LO;
      e_q     <= AW'(DEF_OFS);
      f_q     <= AW'(DEF_OFS);
      clash_q <= 1'b0;
    end else begin
      if (ld_wr) begin
        sel_q <= sel_d;
        e_q   <= e_d;
        f_q   <= f_d;
      end
      clash_q <= clash_d;
    end
  end

  assign ofs_e = e_q;
  assign ofs_f = f_q;
  assign clash = clash_q;

  // R2
  sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> sel_q == sel_next($past(sel_q)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_n |=> ($stable(e_q) && $stable(f_q) && $stable(sel_q)));

  // R12
  clash_wrote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash_q |-> sel_q == sel_next($past(sel_q)));
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import fifo_ofs_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter int DATA_W  = 9,
  parameter int DEF_OFS = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              cfg_n,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              cfg_clash
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HI_W = hi_field_bits(AW);
  localparam int LO_W = AW - HI_W;
  localparam logic [31:0] LO_M = (32'd1 << LO_W) - 32'd1;

  logic              wrst_n, rrst_n;
  logic [AW-1:0]     ofs_e, ofs_f;
  logic [PW-1:0]     wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0]     rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0]     wgray_r, rgray_w, wbin_r, rbin_w;
  logic [PW-1:0]     wcount, rcount;
  logic              rd_req, push, pop, ld_rd;
  ofs_sel_e          rsel_q, rsel_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b = g;
    for (int i = 1; i < PW; i++) b = b ^ (g >> i);
    return b;
  endfunction

  function automatic logic [DATA_W-1:0] field_lo(input logic [AW-1:0] v);
    return DATA_W'(32'(v) & LO_M);
  endfunction

  function automatic logic [DATA_W-1:0] field_hi(input logic [AW-1:0] v);
    return DATA_W'(32'(v) >> LO_W);
  endfunction

  fifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  fifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  fifo_gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r));
  fifo_gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w));

  assign rd_req = !rd_en_a_n && !rd_en_b_n;

  fifo_ofs_bank #(
    .AW(AW), .LO_W(LO_W), .DATA_W(DATA_W), .DEF_OFS(DEF_OFS)
  ) u_bank (
    .clk(wr_clk), .rst_n(wrst_n), .cfg_n(cfg_n), .wr_en_n(wr_en_n),
    .rd_req(rd_req), .din(din), .ofs_e(ofs_e), .ofs_f(ofs_f), .clash(cfg_clash)
  );

  // ---------------- write domain ----------------
  always_comb begin
    rbin_w      = gray2bin(rgray_w);
    wcount      = wbin_q - rbin_w;
    full        = (wcount == PW'(DEPTH));
    almost_full = (PW'(DEPTH) - wcount) <= {1'b0, ofs_f};
    push        = cfg_n && !wr_en_n && !full;
    wbin_d      = wbin_q + PW'(1);
    wgray_d     = bin2gray(wbin_d);
  end

  always_ff @(posedge wr_clk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (push) mem[wbin_q[AW-1:0]] <= din;
  end

  // ---------------- read domain ----------------
  always_comb begin
    wbin_r       = gray2bin(wgray_r);
    rcount       = wbin_r - rbin_q;
    empty        = (rcount == '0);
    almost_empty = rcount <= {1'b0, ofs_e};
    pop          = cfg_n && rd_req && !empty;
    ld_rd        = !cfg_n && rd_req && wr_en_n;
    rbin_d       = rbin_q + PW'(1);
    rgray_d      = bin2gray(rbin_d);
    rsel_d       = sel_next(rsel_q);
    dout_d       = dout_q;
    if (pop) begin
      dout_d = mem[rbin_q[AW-1:0]];
    end else if (ld_rd) begin
      unique case (rsel_q)
        SEL_E_LO: dout_d = field_lo(ofs_e);
        SEL_E_HI: dout_d = field_hi(ofs_e);
        SEL_F_LO: dout_d = field_lo(ofs_f);
        SEL_F_HI: dout_d = field_hi(ofs_f);
      endcase
    end
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rsel_q  <= SEL_E_LO;
      dout_q  <= '0;
    end else begin
      if (pop) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
      end
      if (ld_rd) rsel_q <= rsel_d;
      if (pop || ld_rd) dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  // R8
  full_block_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (full && cfg_n && !wr_en_n) |=> $stable(wbin_q));

  // R8
  depth_bound_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    wcount <= PW'(DEPTH));

  // R9
  empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (empty && cfg_n && rd_req) |=> ($stable(dout) && $stable(rbin_q)));

  // R12
  rd_yield_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (!cfg_n && rd_req && !wr_en_n) |=> ($stable(rsel_q) && $stable(dout)));

  // R5
  rd_step_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    ld_rd |=> rsel_q == sel_next($past(rsel_q)));
endmodule

// File: tb/tb_prog_flag_fifo.sv
module tb_prog_flag_fifo;
  localparam int DEPTH = 512;
  localparam int DW    = 9;
  localparam int AW    = $clog2(DEPTH);
  localparam int HI_W  = (AW <= 8) ? 0 : ((AW == 9) ? 1 : AW - 9);
  localparam int LO_W  = AW - HI_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, wr_en_n, cfg_n, rd_en_a_n, rd_en_b_n;
  logic [DW-1:0] din, dout;
  logic          empty, full, almost_empty, almost_full, cfg_clash;

  prog_flag_fifo #(.DEPTH(DEPTH), .DATA_W(DW), .DEF_OFS(7)) dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .cfg_n(cfg_n),
    .din(din), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .dout(dout),
    .empty(empty), .full(full), .almost_empty(almost_empty),
    .almost_full(almost_full), .cfg_clash(cfg_clash)
  );

  int errors = 0;
  int checks = 0;
  int q[$];
  int ofs_m[4];
  int wsel = 0;
  int rsel = 0;
  int exp_dout = 0;
  int wcnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  function automatic int slot_mask(input int s);
    return ((s % 2) == 0) ? ((1 << LO_W) - 1) : ((1 << HI_W) - 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock of stimulus, then model update and compare
  task automatic step(input logic wn, input logic cn, input logic ra, input logic rb,
                      input int d, input string req);
    int clash_exp;
    wr_en_n = wn; cfg_n = cn; rd_en_a_n = ra; rd_en_b_n = rb; din = DW'(d);
    @(posedge clk);
    @(negedge clk);
    clash_exp = (!wn && !cn && !ra && !rb) ? 1 : 0;
    if (!ra && !rb) begin
      if (!cn) begin
        if (wn) begin
          exp_dout = ofs_m[rsel];
          rsel = (rsel + 1) % 4;
        end
      end else if (q.size() > 0) begin
        exp_dout = q.pop_front();
      end
    end
    if (!wn) begin
      if (!cn) begin
        ofs_m[wsel] = d & slot_mask(wsel);
        wsel = (wsel + 1) % 4;
      end else if (q.size() < DEPTH) begin
        q.push_back(d & ((1 << DW) - 1));
      end
    end
    chk(req, "dout", int'(dout), exp_dout);
    chk("R12", "cfg_clash", int'(cfg_clash), clash_exp);
  endtask

  task automatic settle(input string req);
    int eofs, fofs, n;
    repeat (5) step(1'b1, 1'b1, 1'b1, 1'b1, 0, req);
    eofs = ofs_m[0] | (ofs_m[1] << LO_W);
    fofs = ofs_m[2] | (ofs_m[3] << LO_W);
    n = q.size();
    chk(req, "empty", int'(empty), (n == 0) ? 1 : 0);
    chk("R8", "full", int'(full), (n == DEPTH) ? 1 : 0);
    chk("R10", "almost_empty", int'(almost_empty), (n <= eofs) ? 1 : 0);
    chk("R11", "almost_full", int'(almost_full), ((DEPTH - n) <= fofs) ? 1 : 0);
  endtask

  task automatic push_n(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b1, 1'b1, 1'b1, (wcnt * 37 + 5) & 'h1FF, req);
      wcnt++;
    end
  endtask

  task automatic pop_n(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 0, req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) ofs_m[i] = (i % 2 == 0) ? 7 : 0;
    rst_n = 1'b0; wr_en_n = 1'b1; cfg_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "almost_empty", int'(almost_empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "almost_full", int'(almost_full), 0);
    chk("R1", "cfg_clash", int'(cfg_clash), 0);
    chk("R1", "dout", int'(dout), 0);
    // R1 / R5 default readback: 7,0,7,0 then wrap
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, "R1");

    // R2 / R6 partial load of two slots (high bits of din masked)
    step(1'b0, 1'b0, 1'b1, 1'b1, 'h105, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b1, 'h1FF, "R6");
    // R3 enable high in config mode: no store
    step(1'b1, 1'b0, 1'b1, 1'b1, 'h0AA, "R3");
    // R4 normal traffic between partial loads
    push_n(1, "R4");
    settle("R4");
    pop_n(1, "R4");
    settle("R4");
    // R7 single read enable low does nothing
    step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R7");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R7");
    // R4 resume at slot 2, then R2 wrap to slot 0
    step(1'b0, 1'b0, 1'b1, 1'b1, 'h1F0, "R4");
    step(1'b0, 1'b0, 1'b1, 1'b1, 'h002, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b1, 'h00A, "R2");
    // R5 readback five slots, wrapping
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, "R5");
    settle("R10");

    // empty offset now 266, full offset 240
    push_n(266, "R7");
    settle("R10");
    push_n(1, "R7");
    settle("R10");
    push_n(4, "R7");
    settle("R11");
    push_n(1, "R7");
    settle("R11");
    push_n(DEPTH - 272, "R7");
    settle("R8");
    push_n(3, "R8");
    settle("R8");
    step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R7");
    pop_n(DEPTH - 272, "R7");
    settle("R11");
    pop_n(1, "R7");
    settle("R11");
    pop_n(4, "R7");
    settle("R10");
    pop_n(1, "R7");
    settle("R10");
    pop_n(266, "R7");
    settle("R9");
    pop_n(3, "R9");
    settle("R9");

    // R12 same-edge config write and read: write wins
    step(1'b0, 1'b0, 1'b0, 1'b0, 'h033, "R12");
    step(1'b1, 1'b1, 1'b1, 1'b1, 0, "R12");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, "R12");
    settle("R12");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule